// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Sticky Event Flags

This block is a byte-wide SPI engine on a simple register bus. It works as either bus master or slave. A control/status register holds an enable bit, a two-bit slave-select mode field, a read-only transmit-empty bit and four sticky event flags. The four flags are transfer done, write collision, mode fault and receive overrun. Any flag that is set drives the interrupt. Software clears a flag by writing 0 to its bit. A separate configuration register holds the master-enable bit. A data address writes the one-entry transmit buffer and reads the receive buffer.

Data moves MSB first. The serial clock idles low, and data is sampled on its rising edge and shifted on its falling edge. In master mode the serial clock is a fixed divide of the system clock, and one transfer is eight serial clocks. In slave mode the serial clock, the data input and the slave-select input pass through two-stage synchronizers, so the external clock must be several system clocks per half period. The mode field decides how slave-select is used. It can be ignored (3-wire), used as an input that also detects a competing master, or driven as an output by a single master.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the control register at 0xF8 reads 0x06, the configuration register at 0xF9 reads 0x00, and irq_o, sck_o and ss_oe_o are 0. Control register bits: bit 7 done, bit 6 collision, bit 5 fault, bit 4 overrun, bits 3:2 slave-select mode, bit 1 transmit empty (read only), bit 0 enable. Configuration bit 0 is master enable.
- R2: When enabled as master with a byte pending, the block sends that byte MSB first on sdo_o, valid at each of exactly 8 sck_o rising edges. It captures sdi_i on those edges, and on completion the received byte is readable at 0xFA and bit 7 is set.
- R3: A write to the data address 0xFA clears bit 1. Bit 1 returns to 1 only when the byte moves into the shift register, and no byte moves while bit 0 is 0 or while a transfer is running.
- R4: The four flags stay set until software writes 0 to their bit in the control register. Writing 1 to a flag bit leaves it unchanged.
- R5: irq_o is 1 exactly when at least one of the four flags is set.
- R6: A data write during a transfer sets bit 6, and the write is discarded: the transmit buffer stays empty and the byte being sent is unchanged.
- R7: With enable, master enable and mode 01, a low ss_i sets bit 5, clears the master-enable bit and stops sck_o.
- R8: In slave mode, a transfer that completes while the receive buffer still holds an unread byte sets bit 4 and keeps the old byte. A master-mode completion never sets bit 4.
- R9: In modes 10 and 11 (with enable set), ss_oe_o is 1 and ss_o equals mode bit 0. In modes 00 and 01, ss_oe_o is 0.
- R10: In slave mode the byte in the shift register is presented MSB first on sdo_o before each rising edge of sck_i, and sdi_i is captured on each rising edge. The slave is selected by a low ss_i in mode 01 and always in mode 00.
- R11: With bit 0 clear, sck_o does not toggle and no transfer occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (consumes receive byte) |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| sck_i | input | 1 | Serial clock from external master |
| sck_o | output | 1 | Serial clock generated in master mode |
| sck_oe_o | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| ss_i | input | 1 | Slave-select input, active low |
| ss_o | output | 1 | Slave-select output value |
| ss_oe_o | output | 1 | Slave-select output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle. They check that no flag is lost without a control write, that a colliding write leaves the transmit buffer untouched, and that a mode fault leaves the block outside master mode with no transfer running. They also check that no byte is loaded while the shifter is busy, that the serial clock stays low while disabled, and that overrun arises only in slave mode. The serial waveforms need the bench's scenarios: bit order and edge count in both roles, data returned through the receive buffer, the overrun keeping the old byte, and the slave-select output values.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SS_3WIRE  = 2'b00,
    SS_MULTI  = 2'b01,
    SS_DRV_LO = 2'b10,
    SS_DRV_HI = 2'b11
  } ss_mode_e;

  typedef struct packed {
    logic done;
    logic wcol;
    logic modf;
    logic ovr;
  } spi_evt_t;
endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ctrl_shift.sv
module spi_ctrl_shift #(
  parameter int unsigned DW   = 8,
  parameter int unsigned HALF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          master_i,
  input  logic          sel_i,
  input  logic          abort_i,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          sck_s_i,
  input  logic          sdi_s_i,
  output logic          tx_take_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_data_o,
  output logic          sck_o,
  output logic          sdo_o
);
  localparam int unsigned BW  = (DW > 2) ? $clog2(DW) : 1;
  localparam int unsigned DVW = $clog2(HALF + 1);

  logic [DW-1:0]  sh_q, rx_q, sh_next;
  logic [BW-1:0]  cnt_q;
  logic [DVW-1:0] div_q;
  logic smp_q, sck_q, sck_d_q, mbusy_q, armed_q, done_q;
  logic m_run, s_run, s_act, s_rise, s_fall, div_hit, m_edge, m_rise, m_fall;
  logic m_load, s_load, shift_en, samp_en, last;

  always_comb begin
    m_run    = en_i & master_i & ~abort_i;
    s_run    = en_i & ~master_i;
    s_act    = s_run & sel_i;
    s_rise   = sck_s_i & ~sck_d_q;
    s_fall   = ~sck_s_i & sck_d_q;
    div_hit  = (div_q == DVW'(HALF - 1));
    m_edge   = m_run & mbusy_q & div_hit;
    m_rise   = m_edge & ~sck_q;
    m_fall   = m_edge & sck_q;
    m_load   = m_run & ~mbusy_q & tx_valid_i;
    s_load   = s_run & ~armed_q & (cnt_q == '0) & ~sck_s_i & tx_valid_i;
    shift_en = m_fall | (s_act & s_fall);
    samp_en  = m_rise | (s_act & s_rise);
    last     = shift_en & (cnt_q == BW'(DW - 1));
    sh_next  = {sh_q[DW-2:0], smp_q};
  end

  assign tx_take_o = m_load | s_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      rx_q    <= '0;
      smp_q   <= 1'b0;
      sck_d_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_s_i;
      done_q  <= last;
      if (samp_en) smp_q <= sdi_s_i;
      if (tx_take_o)     sh_q <= tx_data_i;
      else if (shift_en) sh_q <= sh_next;
      if (last) rx_q <= sh_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mbusy_q <= 1'b0;
      div_q   <= '0;
      sck_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (shift_en)                          cnt_q <= last ? '0 : cnt_q + 1'b1;
      else if (!((m_run & mbusy_q) | s_act)) cnt_q <= '0;

      if (!m_run)      mbusy_q <= 1'b0;
      else if (m_load) mbusy_q <= 1'b1;
      else if (last)   mbusy_q <= 1'b0;

      if (!m_run || !mbusy_q || div_hit) div_q <= '0;
      else                               div_q <= div_q + 1'b1;

      if (!m_run || !mbusy_q) sck_q <= 1'b0;
      else if (m_edge)        sck_q <= ~sck_q;

      if (!s_run)      armed_q <= 1'b0;
      else if (s_load) armed_q <= 1'b1;
      else if (last)   armed_q <= 1'b0;
    end
  end

  assign busy_o    = master_i ? mbusy_q : (cnt_q != '0);
  assign done_o    = done_q;
  assign rx_data_o = rx_q;
  assign sck_o     = sck_q;
  assign sdo_o     = sh_q[DW-1];
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = AW'(8'hF8),
  parameter logic [AW-1:0] CFG_ADDR  = AW'(8'hF9),
  parameter logic [AW-1:0] DATA_ADDR = AW'(8'hFA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          en_o,
  output logic          master_o,
  output logic [1:0]    mode_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_take_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          ss_s_i,
  output logic          abort_o,
  output spi_evt_t      evt_o
);
  logic          en_q, master_q, tx_full_q, rx_full_q;
  logic [1:0]    mode_q;
  logic [DW-1:0] tx_q, rx_q;
  spi_evt_t      evt_q;
  logic ctrl_wr, cfg_wr, data_wr, data_rd, modf_hit, wcol_hit, ovr_hit;

  always_comb begin
    ctrl_wr  = we_i & (addr_i == CTRL_ADDR);
    cfg_wr   = we_i & (addr_i == CFG_ADDR);
    data_wr  = we_i & (addr_i == DATA_ADDR);
    data_rd  = re_i & (addr_i == DATA_ADDR);
    modf_hit = en_q & master_q & (mode_q == SS_MULTI) & ~ss_s_i;
    wcol_hit = data_wr & busy_i;
    ovr_hit  = done_i & ~master_q & rx_full_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      mode_q   <= SS_MULTI;
      master_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wdata_i[0];
        mode_q <= wdata_i[3:2];
      end
      if (modf_hit)    master_q <= 1'b0;
      else if (cfg_wr) master_q <= wdata_i[0];
    end
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else begin
      evt_q.done <= done_i   | (evt_q.done & ~(ctrl_wr & ~wdata_i[7]));
      evt_q.wcol <= wcol_hit | (evt_q.wcol & ~(ctrl_wr & ~wdata_i[6]));
      evt_q.modf <= modf_hit | (evt_q.modf & ~(ctrl_wr & ~wdata_i[5]));
      evt_q.ovr  <= ovr_hit  | (evt_q.ovr  & ~(ctrl_wr & ~wdata_i[4]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      tx_full_q <= 1'b0;
      rx_q      <= '0;
      rx_full_q <= 1'b0;
    end else begin
      if (data_wr && !busy_i) begin
        tx_q      <= wdata_i;
        tx_full_q <= 1'b1;
      end else if (tx_take_i) tx_full_q <= 1'b0;

      if (done_i && !ovr_hit) begin
        rx_q      <= rx_data_i;
        rx_full_q <= 1'b1;
      end else if (data_rd) rx_full_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR)
      rdata_o = DW'({evt_q.done, evt_q.wcol, evt_q.modf, evt_q.ovr, mode_q, ~tx_full_q, en_q});
    else if (addr_i == CFG_ADDR)
      rdata_o = DW'(master_q);
    else if (addr_i == DATA_ADDR)
      rdata_o = rx_q;
  end

  assign en_o       = en_q;
  assign master_o   = master_q;
  assign mode_o     = mode_q;
  assign tx_valid_o = tx_full_q;
  assign tx_data_o  = tx_q;
  assign abort_o    = modf_hit;
  assign evt_o      = evt_q;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned HALF = 4,
  parameter logic [AW-1:0] CTRL_ADDR = AW'(8'hF8),
  parameter logic [AW-1:0] CFG_ADDR  = AW'(8'hF9),
  parameter logic [AW-1:0] DATA_ADDR = AW'(8'hFA)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe_o,
  input  logic          sdi_i,
  output logic          sdo_o,
  input  logic          ss_i,
  output logic          ss_o,
  output logic          ss_oe_o,
  output logic          irq_o
);
  logic [2:0]    pin_s;
  logic          sck_s, sdi_s, ss_s;
  logic          en, master, tx_valid, tx_take, busy, done, abort, sel;
  logic [1:0]    mode;
  logic [DW-1:0] tx_data, rx_data;
  spi_evt_t      evt;

  spi_ctrl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, sdi_i, ss_i}),
    .q_o   (pin_s)
  );
  assign {sck_s, sdi_s, ss_s} = pin_s;

  spi_ctrl_regs #(
    .AW(AW), .DW(DW),
    .CTRL_ADDR(CTRL_ADDR), .CFG_ADDR(CFG_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .re_i      (reg_re_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .en_o      (en),
    .master_o  (master),
    .mode_o    (mode),
    .tx_valid_o(tx_valid),
    .tx_data_o (tx_data),
    .tx_take_i (tx_take),
    .busy_i    (busy),
    .done_i    (done),
    .rx_data_i (rx_data),
    .ss_s_i    (ss_s),
    .abort_o   (abort),
    .evt_o     (evt)
  );

  assign sel = (mode == SS_3WIRE) | ~ss_s;

  spi_ctrl_shift #(.DW(DW), .HALF(HALF)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .master_i  (master),
    .sel_i     (sel),
    .abort_i   (abort),
    .tx_valid_i(tx_valid),
    .tx_data_i (tx_data),
    .sck_s_i   (sck_s),
    .sdi_s_i   (sdi_s),
    .tx_take_o (tx_take),
    .busy_o    (busy),
    .done_o    (done),
    .rx_data_o (rx_data),
    .sck_o     (sck_o),
    .sdo_o     (sdo_o)
  );

  assign sck_oe_o = en & master;
  assign ss_oe_o  = en & mode[1];
  assign ss_o     = mode[1] ? mode[0] : 1'b1;
  assign irq_o    = |evt;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctrl_wr_i,
  input logic          data_wr_i,
  input logic [3:0]    evt_i,
  input logic          en_i,
  input logic          master_i,
  input logic          busy_i,
  input logic          tx_take_i,
  input logic          tx_full_i,
  input logic [DW-1:0] tx_data_i,
  input logic          sck_o_i
);
  // evt_i: [3] done, [2] wcol, [1] modf, [0] ovr
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr_i |=> ((evt_i & $past(evt_i)) == $past(evt_i)));  // R4
  AST_WCOL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && busy_i |=> $stable(tx_data_i) && $stable(tx_full_i) && evt_i[2]);  // R6
  AST_MODF_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_i[1]) |-> !master_i && !busy_i);  // R7
  AST_NO_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !tx_take_i);  // R3
  AST_SCK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sck_o_i);  // R11
  AST_OVR_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_i[0]) |-> !master_i);  // R8
endmodule

bind spi_ctrl spi_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_wr_i(reg_we_i && (reg_addr_i == CTRL_ADDR)),
  .data_wr_i(reg_we_i && (reg_addr_i == DATA_ADDR)),
  .evt_i    (evt),
  .en_i     (en),
  .master_i (master),
  .busy_i   (busy),
  .tx_take_i(tx_take),
  .tx_full_i(tx_valid),
  .tx_data_i(tx_data),
  .sck_o_i  (sck_o)
);

// File: tb/sim_spi_ctrl.sv
module sim_spi_ctrl;
  localparam logic [7:0] A_CTRL = 8'hF8, A_CFG = 8'hF9, A_DATA = 8'hFA;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic sck_i = 1'b0, s_sdi = 1'b0, m_sdi = 1'b0, mmode = 1'b1, ss_i = 1'b1;
  logic sdi_i, sck_o, sck_oe_o, sdo_o, ss_o, ss_oe_o, irq_o;
  int nchk = 0, nfail = 0;
  bit fin = 1'b0;

  logic [7:0] sbyte = 8'h00, mcap = 8'h00;
  int bidx = 0, nrise = 0;

  always #4 clk = ~clk;
  assign sdi_i = mmode ? m_sdi : s_sdi;

  spi_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .sdi_i(sdi_i), .sdo_o(sdo_o),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe_o(ss_oe_o), .irq_o(irq_o)
  );

  // slave model answering the block's master clock
  always @(posedge sck_o) begin
    mcap  = {mcap[6:0], sdo_o};
    nrise = nrise + 1;
  end
  always @(negedge sck_o) begin
    if (bidx < 7) begin
      bidx  = bidx + 1;
      m_sdi = sbyte[7-bidx];
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit consume, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = consume;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    logic [7:0] c;
    ok = 1'b0;
    for (int i = 0; i < 1000 && !ok; i++) begin
      rd(A_CTRL, 1'b0, c);
      ok = c[7];
    end
  endtask

  task automatic arm_model(input logic [7:0] sb);
    sbyte = sb; bidx = 0; m_sdi = sb[7]; mcap = 8'h00; nrise = 0;
  endtask

  task automatic check_master(input logic [7:0] tx, input logic [7:0] sb);
    bit ok;
    logic [7:0] d;
    wait_done(ok);
    chk("R2 done flag", {7'b0, ok}, 8'h01);
    chk("R2 mosi byte", mcap, tx);
    chk("R2 sck count", 8'(nrise), 8'd8);
    rd(A_DATA, 1'b1, d);
    chk("R2 rx byte", d, sb);
    rd(A_CTRL, 1'b0, d);
    chk("R8 no overrun in master", {7'b0, d[4]}, 8'h00);
    wr(A_CTRL, 8'h01);
  endtask

  task automatic slave_xfer(input logic [7:0] mb, output logic [7:0] cap);
    cap = 8'h00;
    for (int i = 0; i < 8; i++) begin
      s_sdi = mb[7-i];
      repeat (8) @(negedge clk);
      cap = {cap[6:0], sdo_o};
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [7:0] irq_exp(input logic [7:0] ctrl);
    return {7'b0, |ctrl[7:4]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, cap, tx, sb;
    int r0;
    bit ok;
    r0 = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, 1'b0, d); chk("R1 ctrl reset", d, 8'h06);
    rd(A_CFG, 1'b0, d);  chk("R1 cfg reset", d, 8'h00);
    chk("R1 outputs reset", {4'b0, irq_o, sck_o, ss_oe_o, sck_oe_o}, 8'h00);

    // R3/R11 write while disabled: byte stays in buffer, no clock
    arm_model(8'h93);
    wr(A_DATA, 8'h5A);
    wr(A_CFG, 8'h01);
    repeat (100) @(negedge clk);
    rd(A_CTRL, 1'b0, d); chk("R3 tx not empty while disabled", d, 8'h04);
    chk("R11 no sck while disabled", 8'(nrise), 8'd0);

    // R2 enable master (mode 00): pending byte goes out
    wr(A_CTRL, 8'h01);
    check_master(8'h5A, 8'h93);

    // R2 constrained-random master transfers
    for (int n = 0; n < 6; n++) begin
      tx = 8'($urandom_range(0, 255));
      sb = 8'($urandom_range(0, 255));
      if (n == 0) begin tx = 8'hFF; sb = 8'h00; end
      if (n == 1) begin tx = 8'h00; sb = 8'hFF; end
      arm_model(sb);
      wr(A_DATA, tx);
      check_master(tx, sb);
    end

    // R6 write collision
    arm_model(8'h24);
    wr(A_DATA, 8'hE1);
    repeat (20) @(negedge clk);
    wr(A_DATA, 8'h1E);
    rd(A_CTRL, 1'b0, d);
    chk("R6 wcol set", {7'b0, d[6]}, 8'h01);
    chk("R5 irq on wcol", {7'b0, irq_o}, irq_exp(d));
    wait_done(ok);
    chk("R6 sent byte unchanged", mcap, 8'hE1);
    rd(A_CTRL, 1'b0, d);
    chk("R6 collided write dropped", {7'b0, d[1]}, 8'h01);
    rd(A_DATA, 1'b1, d);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, 1'b0, d);
    chk("R4 flags cleared by zero write", d, 8'h03);
    chk("R5 irq low after clear", {7'b0, irq_o}, 8'h00);

    // R7 mode fault
    ss_i = 1'b1;
    wr(A_CTRL, 8'h05);
    arm_model(8'h00);
    wr(A_DATA, 8'h55);
    repeat (10) @(negedge clk);
    ss_i = 1'b0;
    repeat (10) @(negedge clk);
    rd(A_CTRL, 1'b0, d);
    chk("R7 modf set", {7'b0, d[5]}, 8'h01);
    chk("R5 irq on modf", {7'b0, irq_o}, irq_exp(d));
    rd(A_CFG, 1'b0, d);
    chk("R7 master cleared", d, 8'h00);
    r0 = nrise;
    repeat (100) @(negedge clk);
    chk("R7 sck stopped", 8'(nrise - r0), 8'd0);
    wr(A_CTRL, 8'hF5);
    rd(A_CTRL, 1'b0, d);
    chk("R4 writing one keeps flag", {7'b0, d[5]}, 8'h01);
    wr(A_CTRL, 8'h05);

    // R10 slave mode 01, ss low
    mmode = 1'b0;
    wr(A_DATA, 8'hC3);
    repeat (3) @(negedge clk);
    rd(A_CTRL, 1'b0, d);
    chk("R3 tx empty after load", {7'b0, d[1]}, 8'h01);
    slave_xfer(8'h96, cap);
    chk("R10 slave sdo byte", cap, 8'hC3);
    rd(A_CTRL, 1'b0, d);
    chk("R10 slave done", {7'b0, d[7]}, 8'h01);
    rd(A_DATA, 1'b1, d);
    chk("R10 slave rx byte", d, 8'h96);
    wr(A_CTRL, 8'h05);

    // R8 overrun
    slave_xfer(8'h3C, cap);
    slave_xfer(8'h71, cap);
    rd(A_CTRL, 1'b0, d);
    chk("R8 overrun set", {7'b0, d[4]}, 8'h01);
    chk("R5 irq with overrun", {7'b0, irq_o}, irq_exp(d));
    rd(A_DATA, 1'b1, d);
    chk("R8 old byte kept", d, 8'h3C);
    wr(A_CTRL, 8'h05);

    // R10 mode 00: ss ignored
    ss_i = 1'b1;
    wr(A_CTRL, 8'h01);
    wr(A_DATA, 8'hA5);
    slave_xfer(8'h0F, cap);
    chk("R10 3-wire slave sdo", cap, 8'hA5);
    rd(A_DATA, 1'b1, d);
    chk("R10 3-wire slave rx", d, 8'h0F);
    wr(A_CTRL, 8'h01);

    // R9 slave-select output modes
    wr(A_CTRL, 8'h09);
    chk("R9 mode 10", {6'b0, ss_oe_o, ss_o}, 8'h02);
    wr(A_CTRL, 8'h0D);
    chk("R9 mode 11", {6'b0, ss_oe_o, ss_o}, 8'h03);
    wr(A_CTRL, 8'h05);
    chk("R9 mode 01 no drive", {6'b0, ss_oe_o, 1'b0}, 8'h00);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule